// File: doc/BRIEF.md
# Newton-Raphson Square Root Unit

This block computes the square root of one single-precision (binary32) operand at a time. It never divides. A small computed seed table gives a first estimate of the reciprocal square root. One shared signed fixed-point multiply-add datapath then sharpens that estimate with a fixed number of Newton-Raphson passes. The root is formed as the operand times the reciprocal and then given one more correction pass. A short exact-squaring stage then pins the truncated root to the true floor value. That last step makes round-to-nearest-even exact and gives an honest inexact flag.

Operands that need no arithmetic finish right after acceptance: signed zeros, infinities, NaNs and negative values. Positive operands whose exponent is too small for the iteration to keep its precision are not computed. The unit returns zero for them, lowers its predicate output and raises an assist request, so that a software routine can supply the result. The predicate is high only for results that came out of the iterative path.

A producer presents an operand with `in_valid` and the unit takes it in any cycle where `in_ready` is high. The unit works on it while `busy` is high. It marks completion with a one-cycle `done` pulse. The result and the flags stay on the outputs until the next operand is accepted.

Top module: `nr_sqrt_unit`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle. An operand is taken on a rising edge with `in_valid` and `in_ready` both high. `busy` is high from the cycle after acceptance through the cycle in which `done` is high. `done` lasts one cycle. `in_valid` raised while busy has no effect on the result being computed.
- R2: For a positive normal operand with biased exponent 25 to 254, `result` is the square root rounded to nearest-even. `pred_ok` is 1, and `assist_req` and `flag_invalid` are 0.
- R3: For results from the iterative path, `flag_inexact` is 1 exactly when the true root is not representable. For example, 4.0 gives 2.0 with the flag at 0.
- R4: +0 (0x00000000) returns +0 and -0 (0x80000000) returns -0. `pred_ok`, `assist_req`, `flag_invalid` and `flag_inexact` are all 0.
- R5: +infinity (0x7F800000) returns +infinity with all flags and `pred_ok` at 0.
- R6: A signaling NaN (exponent all ones, nonzero fraction, fraction bit 22 clear) returns 0x7FC00000 with `flag_invalid` 1. A negative nonzero operand does the same, including -infinity and negative denormals. A quiet NaN (fraction bit 22 set) returns 0x7FC00000 with `flag_invalid` 0.
- R7: A positive nonzero operand with biased exponent 0 to 24 returns 0x00000000 with `pred_ok` 0, `assist_req` 1 and the other flags 0. Biased 24 is unbiased -103, which equals the minimum exponent plus the significand width minus one.
- R8: Operands handled without iteration (R4 to R7) raise `done` in the first cycle after acceptance. Iterative operands raise `done` within 24 cycles of acceptance.
- R9: While idle and with no new acceptance, `result`, `pred_ok`, `assist_req` and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present on `in_operand` |
| in_ready | output | 1 | Unit idle and able to take an operand |
| in_operand | input | 32 | binary32 operand |
| busy | output | 1 | Operand in progress, through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | binary32 square root or special value |
| pred_ok | output | 1 | Result came from the iterative path |
| assist_req | output | 1 | Operand needs software handling |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Result was rounded |

## Verification
The bench goes after operands whose roots fall just below or above a rounding boundary. These come from random significands under both exponent parities. An estimate that is one unit off and left uncorrected would return a neighbour of the right value, and a wrong exponent adjustment would halve or double the result. The exponent boundary between 24 and 25 is targeted because an off-by-one threshold either computes a tiny operand or wrongly asks for assistance. Perfect squares such as 4.0 and 1.0 expose a sticky test that reports inexact when nothing was rounded. Signed zero, quiet versus signaling NaN and negative denormals check the priority among the special classes. A reversed order would return the assist pattern or the wrong zero sign.

// File: rtl/nr_sqrt_pkg.sv
package nr_sqrt_pkg;

  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int SIG_N   = MAN_W + 1;
  localparam int BIAS    = 127;
  localparam int EMIN    = 1 - BIAS;
  // Largest biased exponent that still needs software help.
  localparam int ASSIST_LIMIT = EMIN + SIG_N - 1 + BIAS;
  localparam logic [31:0] DEFAULT_QNAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_FIX,
    ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    CL_ROOT,
    CL_DIRECT,
    CL_ASSIST
  } class_e;

  // Digit-by-digit integer square root, floor of sqrt(v).
  function automatic longint unsigned isqrt_u64(input longint unsigned v);
    longint unsigned rem;
    longint unsigned root;
    longint unsigned bitv;
    rem  = v;
    root = 64'd0;
    bitv = 64'd1 << 62;
    for (int k = 0; k < 32; k++) begin
      if (rem >= root + bitv) begin
        rem  = rem - (root + bitv);
        root = (root >> 1) + bitv;
      end else begin
        root = root >> 1;
      end
      bitv = bitv >> 2;
    end
    return root;
  endfunction

endpackage

// File: rtl/nr_sqrt_classify.sv
module nr_sqrt_classify
  import nr_sqrt_pkg::*;
(
  input  logic [31:0] op,
  output class_e      cls,
  output logic [31:0] direct_val,
  output logic        direct_inv
);

  localparam logic [EXP_W-1:0] EXP_ONES   = '1;
  localparam logic [EXP_W-1:0] ASSIST_EXP = EXP_W'(ASSIST_LIMIT);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;

  always_comb begin
    sgn        = op[31];
    ex         = op[30:23];
    fr         = op[22:0];
    cls        = CL_ROOT;
    direct_val = '0;
    direct_inv = 1'b0;
    // Priority: NaN, zero, negative, infinity, tiny.
    if (ex == EXP_ONES && fr != '0) begin
      cls        = CL_DIRECT;
      direct_val = DEFAULT_QNAN;
      direct_inv = ~fr[MAN_W-1];
    end else if (ex == '0 && fr == '0) begin
      cls        = CL_DIRECT;
      direct_val = op;
    end else if (sgn) begin
      cls        = CL_DIRECT;
      direct_val = DEFAULT_QNAN;
      direct_inv = 1'b1;
    end else if (ex == EXP_ONES) begin
      cls        = CL_DIRECT;
      direct_val = op;
    end else if (ex <= ASSIST_EXP) begin
      cls        = CL_ASSIST;
    end
  end

endmodule

// File: rtl/nr_sqrt_seed.sv
module nr_sqrt_seed
  import nr_sqrt_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int SEED_W = 10
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [SEED_W-1:0] seed
);

  localparam int NTAB = 1 << IDX_W;
  localparam int FB   = IDX_W - 1;

  // Entry i: reciprocal root of the midpoint of its interval; top index
  // bit selects the doubled (odd exponent) range.
  function automatic logic [SEED_W-1:0] seed_entry(input int i);
    int              f;
    int              od;
    longint unsigned num;
    longint unsigned den;
    f   = i % (1 << FB);
    od  = i >> FB;
    num = 64'd1 << (2 * SEED_W + FB + 1);
    den = longint'((1 << (FB + 1)) + 2 * f + 1) * longint'(od + 1);
    return SEED_W'(isqrt_u64(num / den));
  endfunction

  logic [SEED_W-1:0] tab [NTAB];

  for (genvar i = 0; i < NTAB; i++) begin : g_tab
    assign tab[i] = seed_entry(i);
  end

  assign seed = tab[idx];

endmodule

// File: rtl/nr_sqrt_fma.sv
module nr_sqrt_fma #(
  parameter int W = 34,
  parameter int F = 30
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  output logic signed [W-1:0] y
);

  localparam logic [2*W-1:0] RND_C = (2*W)'(1) << (F - 1);

  logic [2*W-1:0] prod;
  logic [2*W-1:0] rnd;

  always_comb begin
    prod = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    rnd  = prod + RND_C;
    y    = W'($signed(rnd) >>> F) + c;
  end

endmodule

// File: rtl/nr_sqrt_sqchk.sv
module nr_sqrt_sqchk #(
  parameter int QW = 26,
  parameter int RW = 51
) (
  input  logic [QW-1:0] q,
  input  logic [RW-1:0] r,
  output logic          too_high,
  output logic          too_low,
  output logic          exact
);

  logic [2*QW-1:0] sq;
  logic [2*QW-1:0] sq_next;
  logic [2*QW-1:0] r_ext;

  always_comb begin
    sq       = {{QW{1'b0}}, q} * {{QW{1'b0}}, q};
    sq_next  = sq + (2*QW)'({q, 1'b0}) + (2*QW)'(1);
    r_ext    = (2*QW)'(r);
    too_high = sq > r_ext;
    too_low  = sq_next <= r_ext;
    exact    = sq == r_ext;
  end

endmodule

// File: rtl/nr_sqrt_unit.sv
module nr_sqrt_unit
  import nr_sqrt_pkg::*;
#(
  parameter int FRAC_W = 30,
  parameter int ITERS  = 2,
  parameter int IDX_W  = 6,
  parameter int SEED_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_operand,
  output logic        busy,
  output logic        done,
  output logic [31:0] result,
  output logic        pred_ok,
  output logic        assist_req,
  output logic        flag_invalid,
  output logic        flag_inexact
);

  localparam int W          = FRAC_W + 4;
  localparam int NSTEPS     = 4 * ITERS + 4;
  localparam int STEP_W     = $clog2(NSTEPS);
  localparam int TAIL_START = 4 * ITERS;
  localparam int QW         = SIG_N + 2;
  localparam int RW         = 2 * SIG_N + 3;
  localparam logic signed [W-1:0] HALF = W'(1) << (FRAC_W - 1);
  localparam logic signed [W-1:0] ZERO = '0;

  // ---------------- operand unpacking ----------------
  class_e            in_cls;
  logic [31:0]       in_direct;
  logic              in_dinv;
  logic [EXP_W-1:0]  in_exp;
  logic [SIG_N-1:0]  in_sig;
  logic              in_odd;
  logic [EXP_W:0]    exp_sum;
  logic [W-1:0]      m_load;
  logic [RW-1:0]     r_load;
  logic [EXP_W-1:0]  exp_load;
  logic [IDX_W-1:0]  seed_idx;
  logic [SEED_W-1:0] seed_val;

  nr_sqrt_classify u_cls (
    .op         (in_operand),
    .cls        (in_cls),
    .direct_val (in_direct),
    .direct_inv (in_dinv)
  );

  always_comb begin
    in_exp   = in_operand[30:23];
    in_sig   = {1'b1, in_operand[22:0]};
    in_odd   = ~in_exp[0];
    exp_sum  = {1'b0, in_exp} + (EXP_W+1)'(BIAS) - {{EXP_W{1'b0}}, in_odd};
    exp_load = EXP_W'(exp_sum >> 1);
    m_load   = in_odd ? (W'(in_sig) << (FRAC_W - MAN_W + 1))
                      : (W'(in_sig) << (FRAC_W - MAN_W));
    r_load   = in_odd ? (RW'(in_sig) << (SIG_N + 2))
                      : (RW'(in_sig) << (SIG_N + 1));
    seed_idx = {in_odd, in_operand[MAN_W-1 -: IDX_W-1]};
  end

  nr_sqrt_seed #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_seed (
    .idx  (seed_idx),
    .seed (seed_val)
  );

  // ---------------- state ----------------
  state_e             state_q, state_n;
  logic [STEP_W-1:0]  step_q, step_n;
  logic signed [W-1:0] m_q, m_n;
  logic signed [W-1:0] y_q, y_n;
  logic signed [W-1:0] t_q, t_n;
  logic signed [W-1:0] s_q, s_n;
  logic [QW-1:0]      q_q, q_n;
  logic [RW-1:0]      r_q, r_n;
  logic [EXP_W-1:0]   exp_q, exp_n;
  logic [31:0]        res_q, res_n;
  logic               pred_q, pred_n;
  logic               asst_q, asst_n;
  logic               inv_q, inv_n;
  logic               inx_q, inx_n;

  // ---------------- shared multiply-add ----------------
  logic                tail;
  logic [1:0]          phase;
  logic signed [W-1:0] fa, fb, fc, fy;

  always_comb begin
    tail  = step_q >= STEP_W'(TAIL_START);
    phase = step_q[1:0];
    fa = y_q; fb = y_q; fc = ZERO;
    if (!tail) begin
      case (phase)
        2'd0:    begin fa = y_q; fb = y_q;   fc = ZERO; end // y*y
        2'd1:    begin fa = m_q; fb = t_q;   fc = ZERO; end // a*y^2
        2'd2:    begin fa = t_q; fb = -HALF; fc = HALF; end // error term
        default: begin fa = t_q; fb = y_q;   fc = y_q;  end // y + e*y
      endcase
    end else begin
      case (phase)
        2'd0:    begin fa = m_q; fb = y_q;   fc = ZERO; end // S = a*y
        2'd1:    begin fa = s_q; fb = -s_q;  fc = m_q;  end // a - S^2
        2'd2:    begin fa = y_q; fb = HALF;  fc = ZERO; end // y/2
        default: begin fa = t_q; fb = y_q;   fc = s_q;  end // S + r*y/2
      endcase
    end
  end

  nr_sqrt_fma #(.W(W), .F(FRAC_W)) u_fma (
    .a (fa),
    .b (fb),
    .c (fc),
    .y (fy)
  );

  // ---------------- exact squaring correction ----------------
  logic q_high, q_low, q_exact;
  logic [MAN_W-1:0] man_rnd;

  nr_sqrt_sqchk #(.QW(QW), .RW(RW)) u_chk (
    .q        (q_q),
    .r        (r_q),
    .too_high (q_high),
    .too_low  (q_low),
    .exact    (q_exact)
  );

  assign man_rnd = q_q[MAN_W:1] + {{(MAN_W-1){1'b0}}, q_q[0]};

  // ---------------- next state ----------------
  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    m_n     = m_q;
    y_n     = y_q;
    t_n     = t_q;
    s_n     = s_q;
    q_n     = q_q;
    r_n     = r_q;
    exp_n   = exp_q;
    res_n   = res_q;
    pred_n  = pred_q;
    asst_n  = asst_q;
    inv_n   = inv_q;
    inx_n   = inx_q;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          pred_n = 1'b0;
          asst_n = 1'b0;
          inv_n  = 1'b0;
          inx_n  = 1'b0;
          res_n  = '0;
          if (in_cls == CL_ROOT) begin
            m_n     = m_load;
            y_n     = W'(seed_val) << (FRAC_W - SEED_W);
            r_n     = r_load;
            exp_n   = exp_load;
            step_n  = '0;
            state_n = ST_ITER;
          end else begin
            res_n   = in_direct;
            inv_n   = in_dinv;
            asst_n  = (in_cls == CL_ASSIST);
            state_n = ST_DONE;
          end
        end
      end
      ST_ITER: begin
        step_n = step_q + STEP_W'(1);
        if (!tail) begin
          if (phase == 2'd3) y_n = fy;
          else               t_n = fy;
        end else begin
          case (phase)
            2'd0:    s_n = fy;
            2'd1:    t_n = fy;
            2'd2:    y_n = fy;
            default: begin
              s_n     = fy;
              q_n     = fy[FRAC_W+1 : FRAC_W-SIG_N];
              state_n = ST_FIX;
            end
          endcase
        end
      end
      ST_FIX: begin
        if (q_high) begin
          q_n = q_q - QW'(1);
        end else if (q_low) begin
          q_n = q_q + QW'(1);
        end else begin
          res_n   = {1'b0, exp_q, man_rnd};
          inx_n   = q_q[0] | ~q_exact;
          pred_n  = 1'b1;
          state_n = ST_DONE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      m_q     <= '0;
      y_q     <= '0;
      t_q     <= '0;
      s_q     <= '0;
      q_q     <= '0;
      r_q     <= '0;
      exp_q   <= '0;
      res_q   <= '0;
      pred_q  <= 1'b0;
      asst_q  <= 1'b0;
      inv_q   <= 1'b0;
      inx_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      m_q     <= m_n;
      y_q     <= y_n;
      t_q     <= t_n;
      s_q     <= s_n;
      q_q     <= q_n;
      r_q     <= r_n;
      exp_q   <= exp_n;
      res_q   <= res_n;
      pred_q  <= pred_n;
      asst_q  <= asst_n;
      inv_q   <= inv_n;
      inx_q   <= inx_n;
    end
  end

  assign in_ready     = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign result       = res_q;
  assign pred_ok      = pred_q;
  assign assist_req   = asst_q;
  assign flag_invalid = inv_q;
  assign flag_inexact = inx_q;

endmodule

// File: rtl/nr_sqrt_unit_chk.sv
module nr_sqrt_unit_chk #(
  parameter int LAT_MAX = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        busy,
  input logic        done,
  input logic [31:0] result,
  input logic        pred_ok,
  input logic        assist_req,
  input logic        flag_invalid
);

  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (!busy)            busy_cnt <= '0;
    else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 8'd1;
  end

  // R1
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R7
  a_r7_assist_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && assist_req) |-> (result == 32'h0 && !pred_ok && !flag_invalid));
  // R6
  a_r6_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_invalid) |-> (result == 32'h7FC0_0000 && !pred_ok));
  // R2
  a_r2_positive_root: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pred_ok) |-> (!result[31] && result[30:23] != 8'h00 && !assist_req));
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> ($stable(result) && $stable(pred_ok) && $stable(assist_req)));
  // R8
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 8'(LAT_MAX));

endmodule

bind nr_sqrt_unit nr_sqrt_unit_chk u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .busy         (busy),
  .done         (done),
  .result       (result),
  .pred_ok      (pred_ok),
  .assist_req   (assist_req),
  .flag_invalid (flag_invalid)
);

// File: tb/nr_sqrt_unit_test.sv
module nr_sqrt_unit_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_operand;
  logic        busy;
  logic        done;
  logic [31:0] result;
  logic        pred_ok;
  logic        assist_req;
  logic        flag_invalid;
  logic        flag_inexact;

  int checks;
  int fails;
  bit finished;

  nr_sqrt_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_operand   (in_operand),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .pred_ok      (pred_ok),
    .assist_req   (assist_req),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // Floor square root by binary search.
  function automatic longint unsigned ref_isqrt(input longint unsigned v);
    longint unsigned lo = 0;
    longint unsigned hi = 64'd1 << 27;
    while (hi - lo > 1) begin
      longint unsigned mid = (lo + hi) >> 1;
      if (mid * mid <= v) lo = mid;
      else                hi = mid;
    end
    return lo;
  endfunction

  // Expected outputs from the requirements.
  function automatic void model(input logic [31:0] op, output logic [31:0] r,
                                output logic p, output logic a, output logic inv,
                                output logic inx, output bit direct, output string tag);
    logic [7:0]  e = op[30:23];
    logic [22:0] f = op[22:0];
    r = 32'h0; p = 0; a = 0; inv = 0; inx = 0; direct = 1;
    if (e == 8'hFF && f != 0) begin
      r = 32'h7FC0_0000; inv = ~f[22]; tag = "R6";
    end else if (e == 0 && f == 0) begin
      r = op; tag = "R4";
    end else if (op[31]) begin
      r = 32'h7FC0_0000; inv = 1; tag = "R6";
    end else if (e == 8'hFF) begin
      r = op; tag = "R5";
    end else if (e <= 8'd24) begin
      a = 1; tag = "R7";
    end else begin
      longint unsigned sig = {41'd0, 1'b1, f};
      int odd = (e[0] == 1'b0) ? 1 : 0;
      longint unsigned rr = sig << (25 + odd);
      longint unsigned q = ref_isqrt(rr);
      longint unsigned rs = (q >> 1) + (q & 1);
      int ex = (int'(e) + 127 - odd) / 2;
      r = {1'b0, 8'(ex), rs[22:0]};
      p = 1; inx = (q * q != rr); direct = 0; tag = "R2";
    end
  endfunction

  task automatic apply(input logic [31:0] op, input bit hammer, input bit hold);
    logic [31:0] er;
    logic ep, ea, ei, ex;
    bit direct;
    string tag;
    int cyc;
    model(op, er, ep, ea, ei, ex, direct, tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_operand = op;
    @(posedge clk);
    #1;
    if (hammer) in_operand = ~op;
    else begin in_valid = 1'b0; in_operand = $urandom; end
    @(negedge clk);
    cyc = 1;
    check(busy && !in_ready, "R1", "busy after accept", {30'd0, busy, in_ready}, 32'h2);
    while (!done && cyc < 100) begin
      if (hammer && cyc == 3) in_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    if (!done) begin
      check(0, "R8", "no done", 32'(cyc), 32'd24);
      return;
    end
    if (direct) check(cyc == 1, "R8", "direct latency", 32'(cyc), 32'd1);
    else        check(cyc <= 24, "R8", "iterative latency", 32'(cyc), 32'd24);
    check(result == er, tag, $sformatf("result op=%08h", op), result, er);
    check({pred_ok, assist_req, flag_invalid} == {ep, ea, ei}, tag,
          $sformatf("pred/assist/invalid op=%08h", op),
          {29'd0, pred_ok, assist_req, flag_invalid}, {29'd0, ep, ea, ei});
    if (!direct)
      check(flag_inexact == ex, "R3", $sformatf("inexact op=%08h", op),
            {31'd0, flag_inexact}, {31'd0, ex});
    else
      check(flag_inexact == 1'b0, tag, "inexact on direct", {31'd0, flag_inexact}, 32'd0);
    @(negedge clk);
    check(!done && !busy && in_ready, "R1", "return to idle",
          {29'd0, done, busy, in_ready}, 32'd1);
    if (hold) begin
      repeat (3) @(negedge clk);
      check(result == er && pred_ok == ep && assist_req == ea && flag_invalid == ei,
            "R9", "outputs held while idle", result, er);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_operand = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !busy && !done && result == 0 && !pred_ok && !assist_req,
          "R1", "reset state", result, 32'h0);
    // Directed corners
    apply(32'h0000_0000, 0, 1); // R4 +0
    apply(32'h8000_0000, 0, 1); // R4 -0
    apply(32'h7F80_0000, 0, 0); // R5 +inf
    apply(32'hFF80_0000, 0, 0); // R6 -inf
    apply(32'hBF80_0000, 0, 0); // R6 -1.0
    apply(32'h8000_0001, 0, 0); // R6 negative denormal
    apply(32'h7F80_0001, 0, 1); // R6 signaling NaN
    apply(32'h7FC0_0001, 0, 0); // R6 quiet NaN
    apply(32'h0000_0001, 0, 1); // R7 denormal
    apply(32'h0C7F_FFFF, 0, 0); // R7 biased 24
    apply(32'h0C80_0000, 0, 0); // R2 biased 25
    apply(32'h4080_0000, 0, 1); // R3 4.0 exact
    apply(32'h3F80_0000, 0, 0); // R3 1.0 exact
    apply(32'h4000_0000, 0, 0); // R2 2.0
    apply(32'h7F7F_FFFF, 0, 0); // R2 largest finite
    apply(32'h4110_0000, 1, 1); // R1 in_valid held while busy (9.0)
    // Random positive normals in the iterative range
    for (int i = 0; i < 1200; i++) begin
      logic [7:0] e = 8'(25 + $urandom_range(0, 229));
      apply({1'b0, e, 23'($urandom)}, 0, (i % 97) == 0);
    end
    // Random patterns across all classes
    for (int i = 0; i < 300; i++) apply($urandom, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule